// File: doc/BRIEF.md
# Pseudorandom Noise Source

This block turns a pseudorandom 32-bit integer stream into fixed-point noise samples. A parameter chooses one of three integer engines: a 32-bit Galois shift register (the default), a linear congruential generator whose sequence is bit-exact with the standard Verilog `$random` recurrence, or a 32-bit Mersenne Twister. A second parameter chooses how the raw word is shaped. In uniform mode the output spans a configurable half-open range. In Gaussian mode the output is an approximate normal variate with a configurable mean and standard deviation, built from a sum of twelve uniform terms.

Each enabled cycle advances the engine by one step and registers a new sample. The raw word is also registered and made available as an unsigned Q0.32 fraction in [0,1), for use by external inverse-distribution lookups. A seed strobe replaces the default seed at any time. The Mersenne Twister has to fill its 624-word state before it can produce output, and it reports readiness while it does so.

Top module: `noise_source`

## Requirements
- R1: With the Mersenne Twister engine, `ready` is low for exactly 624 cycles after reset is released or after a seed load, then rises. With the other two engines `ready` is always high. No step is taken while `ready` is low.
- R2: Shift-register engine: the state steps as next = (s >> 1) XOR (s[0] ? 32'h80200003 : 0). `unitOut` shows the new state after each step. The state after reset is the `SEED` parameter (default 5489).
- R3: Shift-register engine: a seed of zero is replaced by 32'h5EED0001, so the state never becomes zero.
- R4: Congruential engine: the state steps as s*69069 + 1 modulo 2^32, and `unitOut` shows the new state. From seed 5489 the first value is 379119742.
- R5: Twister engine: `unitOut` follows the standard MT19937 sequence for the loaded seed. For seed 5489 the first word is 32'hD091BB5C.
- R6: Uniform shaping: sample = UNI_MIN + floor((UNI_MAX-UNI_MIN)*u/65536), where u = unitOut[31:16]. The sample therefore lies in [UNI_MIN, UNI_MAX).
- R7: Gaussian shaping: sample = G_MEAN + floor(G_STD*(S - 393216)/65536), where S is the sum of the upper 16 bits of the current word and the previous 11 words. Missing words since reset or the last seed load count as zero.
- R8: When `enable` is low, the engine state, `unitOut` and `sampleOut` hold.
- R9: `seedLoad` takes priority over `enable`. In that cycle the outputs hold and the seed is taken from `seedValue`. The Gaussian window is cleared, and the twister restarts its fill.
- R10: During reset, `unitOut` and `sampleOut` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Advance one step this cycle |
| seedLoad | input | 1 | Load `seedValue` as the new seed |
| seedValue | input | 32 | Seed to load |
| ready | output | 1 | Engine can produce samples |
| unitOut | output | 32 | Last raw word as a Q0.32 fraction in [0,1) |
| sampleOut | output | OUT_W | Shaped signed fixed-point sample |

## Verification
The hardest situation to reach is a reseed of the twister in the middle of a run. The whole 624-word state must be rebuilt while `enable` keeps toggling, and the first word after the refill must match the new seed's sequence. The stimulus loads seeds of zero and 32'hDEADBEEF, and also issues a load in the same cycle as `enable`. It then runs enough gated cycles to cover the full refill and the following twist. The bench checks three instances against models in the bench on every cycle: the shift register with uniform shaping, the congruential engine with Gaussian shaping, and the twister with uniform shaping.

// File: rtl/noise_pkg.sv
package noise_pkg;
  typedef enum logic [1:0] {ENG_LFSR, ENG_LCG, ENG_MT} engine_e;
  typedef enum logic {SHAPE_UNIFORM, SHAPE_GAUSS} shape_e;

  localparam int MT_N  = 624;
  localparam int MT_M  = 397;
  localparam int IDX_W = $clog2(MT_N);

  localparam logic [31:0] LFSR_MASK     = 32'h8020_0003;
  localparam logic [31:0] LFSR_ZERO_SUB = 32'h5EED_0001;
  localparam logic [31:0] LCG_MUL       = 32'd69069;
  localparam logic [31:0] MT_MATRIX     = 32'h9908_B0DF;
  localparam logic [31:0] MT_INIT_MUL   = 32'd1812433253;

  typedef struct packed {
    logic             load;
    logic             init;
    logic             gen;
    logic [IDX_W-1:0] idx;
  } ctl_t;

  function automatic logic [31:0] mtTemper(input logic [31:0] v);
    logic [31:0] t;
    t = v ^ (v >> 11);
    t = t ^ ((t << 7) & 32'h9D2C_5680);
    t = t ^ ((t << 15) & 32'hEFC6_0000);
    t = t ^ (t >> 18);
    return t;
  endfunction
endpackage

// File: rtl/noise_engine.sv
module noise_engine import noise_pkg::*; #(
  parameter engine_e     ENGINE = ENG_LFSR,
  parameter logic [31:0] SEED   = 32'd5489
) (
  input  logic        clk,
  input  logic        rst,
  input  ctl_t        ctl,
  input  logic [31:0] seedValue,
  output logic [31:0] word
);
  generate
    if (ENGINE == ENG_MT) begin : gMt
      localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MT_N - 1);
      localparam logic [IDX_W-1:0] FAR_OFS  = IDX_W'(MT_M);
      localparam logic [IDX_W-1:0] WRAP_OFS = IDX_W'(MT_N - MT_M);
      logic [31:0] mt [MT_N];
      logic [31:0] seedQ, prevQ, initVal, mixed, twisted;
      logic [IDX_W-1:0] iNext, iFar;

      always_comb begin
        iNext   = (ctl.idx == LAST_IDX) ? '0 : ctl.idx + 1'b1;
        iFar    = (ctl.idx < WRAP_OFS) ? ctl.idx + FAR_OFS : ctl.idx - WRAP_OFS;
        initVal = (ctl.idx == '0) ? seedQ
                : MT_INIT_MUL * (prevQ ^ (prevQ >> 30)) + 32'(ctl.idx);
        mixed   = {mt[ctl.idx][31], mt[iNext][30:0]};
        twisted = mt[iFar] ^ (mixed >> 1) ^ (mixed[0] ? MT_MATRIX : 32'h0);
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          seedQ <= SEED;
          prevQ <= '0;
        end else begin
          if (ctl.load) seedQ <= seedValue;
          if (ctl.init) prevQ <= initVal;
        end
      end

      always_ff @(posedge clk) begin
        if (ctl.init)     mt[ctl.idx] <= initVal;
        else if (ctl.gen) mt[ctl.idx] <= twisted;
      end

      assign word = mtTemper(twisted);
    end else begin : gShift
      localparam logic [31:0] RESET_STATE =
        (ENGINE == ENG_LFSR && SEED == 32'h0) ? LFSR_ZERO_SUB : SEED;
      logic [31:0] stateQ, nextState, loadVal;
      logic unusedShiftCtl;

      always_comb begin
        if (ENGINE == ENG_LFSR) begin
          nextState = (stateQ >> 1) ^ (stateQ[0] ? LFSR_MASK : 32'h0);
          loadVal   = (seedValue == 32'h0) ? LFSR_ZERO_SUB : seedValue;
        end else begin
          nextState = stateQ * LCG_MUL + 32'd1;
          loadVal   = seedValue;
        end
      end

      always_ff @(posedge clk) begin
        if (rst)          stateQ <= RESET_STATE;
        else if (ctl.load) stateQ <= loadVal;
        else if (ctl.gen)  stateQ <= nextState;
      end

      assign word = nextState;
      assign unusedShiftCtl = ^{ctl.init, ctl.idx};
    end
  endgenerate
endmodule

// File: rtl/noise_shaper.sv
module noise_shaper import noise_pkg::*; #(
  parameter shape_e SHAPE   = SHAPE_UNIFORM,
  parameter int     OUT_W   = 16,
  parameter int     UNI_MIN = -315,
  parameter int     UNI_MAX = 1167,
  parameter int     G_MEAN  = 1167,
  parameter int     G_STD   = 315
) (
  input  logic                    clk,
  input  logic                    rst,
  input  ctl_t                    ctl,
  input  logic [31:0]             word,
  output logic [31:0]             unitOut,
  output logic signed [OUT_W-1:0] sampleOut
);
  localparam int GAUSS_TAPS = 12;
  localparam int SUM_W      = $clog2(GAUSS_TAPS * 65535 + 1);
  localparam int GAUSS_BIAS = (GAUSS_TAPS / 2) * 65536;
  localparam int unusedParamMix = UNI_MIN ^ UNI_MAX ^ G_MEAN ^ G_STD;

  logic [15:0] u16;
  logic signed [OUT_W-1:0] shaped;
  logic unusedShaperCtl;

  assign u16 = word[31:16];
  assign unusedShaperCtl = ^{ctl.init, ctl.idx, ctl.load};

  generate
    if (SHAPE == SHAPE_UNIFORM) begin : gUniform
      logic signed [63:0] spanProd;
      assign spanProd = 64'(UNI_MAX - UNI_MIN) * $signed({48'd0, u16});
      assign shaped   = OUT_W'(64'(UNI_MIN) + (spanProd >>> 16));
    end else begin : gGauss
      logic [15:0] win [GAUSS_TAPS];
      logic [SUM_W-1:0] sumQ, sumNext;
      logic signed [63:0] centered, gProd;

      assign sumNext  = sumQ + SUM_W'(u16) - SUM_W'(win[GAUSS_TAPS-1]);
      assign centered = $signed(64'(sumNext)) - 64'(GAUSS_BIAS);
      assign gProd    = 64'(G_STD) * centered;
      assign shaped   = OUT_W'(64'(G_MEAN) + (gProd >>> 16));

      always_ff @(posedge clk) begin
        if (rst || ctl.load) begin
          sumQ <= '0;
          for (int k = 0; k < GAUSS_TAPS; k++) win[k] <= '0;
        end else if (ctl.gen) begin
          sumQ   <= sumNext;
          win[0] <= u16;
          for (int k = 1; k < GAUSS_TAPS; k++) win[k] <= win[k-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      unitOut   <= '0;
      sampleOut <= '0;
    end else if (ctl.gen) begin
      unitOut   <= word;
      sampleOut <= shaped;
    end
  end
endmodule

// File: rtl/noise_ctrl.sv
module noise_ctrl import noise_pkg::*; #(
  parameter engine_e ENGINE = ENG_LFSR
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic seedLoad,
  output ctl_t ctl,
  output logic ready
);
  localparam logic RUN_AT_START = (ENGINE != ENG_MT);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MT_N - 1);

  logic runQ;
  logic [IDX_W-1:0] idxQ, idxInc;

  assign idxInc = (idxQ == LAST_IDX) ? '0 : idxQ + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || seedLoad) begin
      runQ <= RUN_AT_START;
      idxQ <= '0;
    end else if (!runQ) begin
      idxQ <= idxInc;
      if (idxQ == LAST_IDX) runQ <= 1'b1;
    end else if (enable) begin
      idxQ <= idxInc;
    end
  end

  always_comb begin
    ctl.load = !rst && seedLoad;
    ctl.init = !rst && !seedLoad && !runQ;
    ctl.gen  = !rst && !seedLoad && runQ && enable;
    ctl.idx  = idxQ;
  end

  assign ready = runQ;
endmodule

// File: rtl/noise_datapath.sv
module noise_datapath import noise_pkg::*; #(
  parameter engine_e     ENGINE  = ENG_LFSR,
  parameter shape_e      SHAPE   = SHAPE_UNIFORM,
  parameter int          OUT_W   = 16,
  parameter logic [31:0] SEED    = 32'd5489,
  parameter int          UNI_MIN = -315,
  parameter int          UNI_MAX = 1167,
  parameter int          G_MEAN  = 1167,
  parameter int          G_STD   = 315
) (
  input  logic                    clk,
  input  logic                    rst,
  input  ctl_t                    ctl,
  input  logic [31:0]             seedValue,
  output logic [31:0]             unitOut,
  output logic signed [OUT_W-1:0] sampleOut
);
  logic [31:0] word;

  noise_engine #(.ENGINE(ENGINE), .SEED(SEED)) uEngine (
    .clk(clk), .rst(rst), .ctl(ctl), .seedValue(seedValue), .word(word)
  );

  noise_shaper #(
    .SHAPE(SHAPE), .OUT_W(OUT_W), .UNI_MIN(UNI_MIN), .UNI_MAX(UNI_MAX),
    .G_MEAN(G_MEAN), .G_STD(G_STD)
  ) uShaper (
    .clk(clk), .rst(rst), .ctl(ctl), .word(word),
    .unitOut(unitOut), .sampleOut(sampleOut)
  );
endmodule

// File: rtl/noise_source.sv
module noise_source import noise_pkg::*; #(
  parameter engine_e     ENGINE  = ENG_LFSR,
  parameter shape_e      SHAPE   = SHAPE_UNIFORM,
  parameter int          OUT_W   = 16,
  parameter logic [31:0] SEED    = 32'd5489,
  parameter int          UNI_MIN = -315,
  parameter int          UNI_MAX = 1167,
  parameter int          G_MEAN  = 1167,
  parameter int          G_STD   = 315
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    enable,
  input  logic                    seedLoad,
  input  logic [31:0]             seedValue,
  output logic                    ready,
  output logic [31:0]             unitOut,
  output logic signed [OUT_W-1:0] sampleOut
);
  ctl_t ctl;

  noise_ctrl #(.ENGINE(ENGINE)) uCtrl (
    .clk(clk), .rst(rst), .enable(enable), .seedLoad(seedLoad),
    .ctl(ctl), .ready(ready)
  );

  noise_datapath #(
    .ENGINE(ENGINE), .SHAPE(SHAPE), .OUT_W(OUT_W), .SEED(SEED),
    .UNI_MIN(UNI_MIN), .UNI_MAX(UNI_MAX), .G_MEAN(G_MEAN), .G_STD(G_STD)
  ) uDatapath (
    .clk(clk), .rst(rst), .ctl(ctl), .seedValue(seedValue),
    .unitOut(unitOut), .sampleOut(sampleOut)
  );
endmodule

// File: rtl/noise_source_chk.sv
module noise_source_chk import noise_pkg::*; #(
  parameter engine_e ENGINE  = ENG_LFSR,
  parameter shape_e  SHAPE   = SHAPE_UNIFORM,
  parameter int      OUT_W   = 16,
  parameter int      UNI_MIN = -315,
  parameter int      UNI_MAX = 1167
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    enable,
  input logic                    seedLoad,
  input logic                    ready,
  input logic [31:0]             unitOut,
  input logic signed [OUT_W-1:0] sampleOut
);
  localparam int unusedChkMix = UNI_MIN ^ UNI_MAX;
  logic step;
  assign step = enable && ready && !seedLoad;

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(unitOut) && $stable(sampleOut)));

  assert_load_hold_R9: assert property (@(posedge clk) disable iff (rst)
    seedLoad |=> ($stable(unitOut) && $stable(sampleOut)));

  generate
    if (ENGINE == ENG_MT) begin : gMtChk
      assert_load_drops_ready_R9: assert property (@(posedge clk) disable iff (rst)
        seedLoad |=> !ready);
    end else begin : gShiftChk
      assert_always_ready_R1: assert property (@(posedge clk) disable iff (rst)
        ready);
    end

    if (ENGINE == ENG_LFSR) begin : gLfsrChk
      assert_lfsr_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
        $past(step) |-> (unitOut != 32'h0));
    end

    if (ENGINE == ENG_LCG) begin : gLcgChk
      assert_lcg_recurrence_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(step) && $past(step, 2)) |->
        (unitOut == 32'($past(unitOut) * 32'd69069 + 32'd1)));
    end

    if (SHAPE == SHAPE_UNIFORM) begin : gUniChk
      assert_uniform_range_R6: assert property (@(posedge clk) disable iff (rst)
        $past(step) |-> (sampleOut >= UNI_MIN && sampleOut < UNI_MAX));
    end
  endgenerate
endmodule

bind noise_source noise_source_chk #(
  .ENGINE(ENGINE), .SHAPE(SHAPE), .OUT_W(OUT_W),
  .UNI_MIN(UNI_MIN), .UNI_MAX(UNI_MAX)
) uChk (
  .clk(clk), .rst(rst), .enable(enable), .seedLoad(seedLoad),
  .ready(ready), .unitOut(unitOut), .sampleOut(sampleOut)
);

// File: tb/noise_source_test.sv
module noise_source_test;
  import noise_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int OUT_W   = 16;
  localparam int UNI_MIN = -315;
  localparam int UNI_MAX = 1167;
  localparam int G_MEAN  = 1167;
  localparam int G_STD   = 315;
  localparam logic [31:0] SEED = 32'd5489;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic seedLoad = 1'b0;
  logic [31:0] seedValue = 32'h0;

  logic readyL, readyC, readyM;
  logic [31:0] unitL, unitC, unitM;
  logic signed [OUT_W-1:0] sampleL, sampleC, sampleM;

  always #(CLK_PERIOD/2) clk = ~clk;

  noise_source #(.ENGINE(ENG_LFSR), .SHAPE(SHAPE_UNIFORM)) uut (
    .clk(clk), .rst(rst), .enable(enable), .seedLoad(seedLoad), .seedValue(seedValue),
    .ready(readyL), .unitOut(unitL), .sampleOut(sampleL));

  noise_source #(.ENGINE(ENG_LCG), .SHAPE(SHAPE_GAUSS)) uutLcg (
    .clk(clk), .rst(rst), .enable(enable), .seedLoad(seedLoad), .seedValue(seedValue),
    .ready(readyC), .unitOut(unitC), .sampleOut(sampleC));

  noise_source #(.ENGINE(ENG_MT), .SHAPE(SHAPE_UNIFORM)) uutMt (
    .clk(clk), .rst(rst), .enable(enable), .seedLoad(seedLoad), .seedValue(seedValue),
    .ready(readyM), .unitOut(unitM), .sampleOut(sampleM));

  int checks = 0;
  int errors = 0;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct {
    logic [31:0] uL, uC, uM;
    int sL, sC, sM;
    logic rM;
    string tag;
  } exp_t;
  exp_t expQ[$];

  logic [31:0] lfsrS, lcgS;
  logic [31:0] mtA [624];
  int mtI;
  int gWin [12];
  int busyM;
  exp_t cur;

  function automatic logic [31:0] lfsrStep(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? 32'h8020_0003 : 32'h0);
  endfunction

  function automatic int uniShape(input logic [31:0] w);
    longint p;
    p = longint'(UNI_MAX - UNI_MIN) * longint'(w[31:16]);
    return UNI_MIN + int'(p / 65536);
  endfunction

  function automatic int gaussShape();
    longint s, p, q;
    s = 0;
    for (int k = 0; k < 12; k++) s += gWin[k];
    p = longint'(G_STD) * (s - 393216);
    q = p / 65536;
    if (p < 0 && q * 65536 != p) q--;
    return G_MEAN + int'(q);
  endfunction

  task automatic mtSeed(input logic [31:0] v);
    mtA[0] = v;
    for (int i = 1; i < 624; i++)
      mtA[i] = 32'd1812433253 * (mtA[i-1] ^ (mtA[i-1] >> 30)) + 32'(i);
    mtI = 624;
  endtask

  task automatic mtNext(output logic [31:0] w);
    logic [31:0] y;
    if (mtI >= 624) begin
      for (int i = 0; i < 624; i++) begin
        y = (mtA[i] & 32'h8000_0000) | (mtA[(i+1) % 624] & 32'h7FFF_FFFF);
        mtA[i] = mtA[(i+397) % 624] ^ (y >> 1) ^ (y[0] ? 32'h9908_B0DF : 32'h0);
      end
      mtI = 0;
    end
    y = mtA[mtI];
    mtI++;
    y = y ^ (y >> 11);
    y = y ^ ((y << 7) & 32'h9D2C_5680);
    y = y ^ ((y << 15) & 32'hEFC6_0000);
    w = y ^ (y >> 18);
  endtask

  // Driver: one call is one clock cycle; pushes the expected outputs
  task automatic cycle(input bit en, input bit ld, input logic [31:0] v, input string tag);
    logic [31:0] w;
    @(negedge clk);
    rst = 1'b0;
    enable = en;
    seedLoad = ld;
    seedValue = v;
    if (ld) begin
      lfsrS = (v == 32'h0) ? 32'h5EED_0001 : v;
      lcgS = v;
      for (int k = 0; k < 12; k++) gWin[k] = 0;
      mtSeed(v);
      busyM = 624;
      cur.rM = 1'b0;
    end else begin
      if (en) begin
        lfsrS = lfsrStep(lfsrS);
        cur.uL = lfsrS;
        cur.sL = uniShape(lfsrS);
        lcgS = lcgS * 32'd69069 + 32'd1;
        cur.uC = lcgS;
        for (int k = 11; k > 0; k--) gWin[k] = gWin[k-1];
        gWin[0] = int'(lcgS[31:16]);
        cur.sC = gaussShape();
      end
      if (busyM > 0) begin
        busyM--;
        if (busyM == 0) cur.rM = 1'b1;
      end else if (en) begin
        mtNext(w);
        cur.uM = w;
        cur.sM = uniShape(w);
      end
    end
    cur.tag = tag;
    expQ.push_back(cur);
  endtask

  // Monitor: compares one expected item per clock, a quarter period after the edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        check({e.tag, " R2 lfsr unit"}, longint'(unitL), longint'(e.uL));
        check({e.tag, " R6 lfsr sample"}, longint'(sampleL), longint'(e.sL));
        check({e.tag, " R4 lcg unit"}, longint'(unitC), longint'(e.uC));
        check({e.tag, " R7 gauss sample"}, longint'(sampleC), longint'(e.sC));
        check({e.tag, " R5 mt unit"}, longint'(unitM), longint'(e.uM));
        check({e.tag, " R6 mt sample"}, longint'(sampleM), longint'(e.sM));
        check({e.tag, " R1 mt ready"}, longint'(readyM), longint'(e.rM));
        check({e.tag, " R1 lfsr ready"}, longint'(readyL), 1);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    lfsrS = SEED;
    lcgS = SEED;
    mtSeed(SEED);
    for (int k = 0; k < 12; k++) gWin[k] = 0;
    busyM = 624;
    cur.uL = 0; cur.uC = 0; cur.uM = 0;
    cur.sL = 0; cur.sC = 0; cur.sM = 0;
    cur.rM = 1'b0;

    repeat (3) @(negedge clk);
    // R10: outputs zero during reset
    check("R10 lfsr unit", longint'(unitL), 0);
    check("R10 lcg sample", longint'(sampleC), 0);
    check("R10 mt unit", longint'(unitM), 0);
    check("R10 mt sample", longint'(sampleM), 0);
    check("R1 lcg ready in reset", longint'(readyC), 1);
    check("R1 mt ready in reset", longint'(readyM), 0);

    // R1: twister fill after reset, others idle (R8)
    for (int i = 0; i < 624; i++) cycle(1'b0, 1'b0, 32'h0, "R1 R8 fill");

    cycle(1'b1, 1'b0, 32'h0, "R2 first step");
    @(posedge clk);
    #(CLK_PERIOD/4 + 1);
    check("R5 mt first word", longint'(unitM), longint'(32'hD091_BB5C));
    check("R4 lcg first word", longint'(unitC), 379119742);

    for (int i = 0; i < 40; i++) cycle(1'b1, 1'b0, 32'h0, "R6 R7 run");
    for (int i = 0; i < 12; i++) cycle(i % 3 != 1, 1'b0, 32'h0, "R8 gated");

    // R9 + R3: zero seed, then a twister refill with gated enable
    cycle(1'b0, 1'b1, 32'h0, "R9 R3 load zero");
    cycle(1'b1, 1'b0, 32'h0, "R3 after zero seed");
    @(posedge clk);
    #(CLK_PERIOD/4 + 1);
    check("R3 lfsr zero seed substitute", longint'(unitL), longint'(lfsrStep(32'h5EED_0001)));
    for (int i = 0; i < 700; i++) cycle(i % 4 != 3, 1'b0, 32'h0, "R9 reseed run");

    // R9: load together with enable; load wins
    cycle(1'b1, 1'b1, 32'hDEAD_BEEF, "R9 load with enable");
    for (int i = 0; i < 640; i++) cycle(1'b1, 1'b0, 32'h0, "R9 after load");
    cycle(1'b0, 1'b0, 32'h0, "R8 final idle");
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4 + 1);
    check("R9 queue drained", longint'(expQ.size()), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule